// File: doc/BRIEF.md
# Dual-Port Emulating Memory Arbiter

The block connects a core that issues a pair of data operand accesses every cycle to a data memory space. The space is divided into regions by the top address bits. A configuration vector marks each region as either true dual-port storage or a single-port bank. The core always sees the same two-operand interface whatever the mix. Each accepted pair is carried out over two internal buses. Each single-port bank is wired to one home bus, chosen by the LSB of its region index. When exactly one operand targets a single-port bank, the other operand, which targets dual-port storage, is steered onto the other bus. No cycle is lost.

Only two single-port accesses that need the same home bus in one cycle conflict. The block then withholds `in_ready` for one cycle, which is a wait state. It serves operand 0 in that cycle and operand 1 in the next, then returns both results together. The request side is valid/ready. While `in_ready` is low, the core must hold `in_valid` and all operand fields stable. The pair is accepted on the edge where both `in_valid` and `in_ready` are high. The response side has no back-pressure: `rsp_valid` pulses for one cycle, one cycle after acceptance. A free-running counter records the wait states, so stall cost can be compared across configurations.

Top module: `dpe_arbiter`

## Requirements
- R1: After reset, `rsp_valid` is low and `stall_count` is zero.
- R2: Region index k is `addr[ADDR_W-1 -: REG_BITS]`. `cfg_single[k]=1` makes region k a single-port bank on home bus k[0], and 0 makes it dual-port.
- R3: A pair that needs no wait is accepted in the cycle it is presented (`in_ready` high). `rsp_valid` is high in the next cycle and carries both results.
- R4: When both operands target single-port regions whose indices have equal LSBs, `in_ready` is low for exactly one cycle of the presentation. It is high in the second cycle, and the response follows the cycle after acceptance.
- R5: If at most one operand targets a single-port region, the pair never waits. This covers the case where the dual-port operand is steered to the other bus, and the case where both operands are dual-port.
- R6: A pair behaves as operand 0 followed by operand 1. A read returns the stored word, including a write by operand 0 of the same pair to the same address. If both operands write one address, operand 1's data remains.
- R7: For the same access stream, the read results are identical under every value of `cfg_single`; only cycle counts differ.
- R8: `stall_count` increases by one for each cycle in which `in_valid` is high and `in_ready` is low.
- R9: The result returned for an operand whose write enable was set is zero.
- R10: No response is produced during a wait cycle. A held request is accepted only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_single | input | 2**REG_BITS | Per-region single-port flag |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Pair accepted this cycle; low is a wait state |
| addr0 | input | ADDR_W | Operand 0 address |
| we0 | input | 1 | Operand 0 write enable |
| wdata0 | input | DATA_W | Operand 0 write data |
| addr1 | input | ADDR_W | Operand 1 address |
| we1 | input | 1 | Operand 1 write enable |
| wdata1 | input | DATA_W | Operand 1 write data |
| rsp_valid | output | 1 | Results valid |
| rdata0 | output | DATA_W | Operand 0 result |
| rdata1 | output | DATA_W | Operand 1 result |
| stall_count | output | CNT_W | Wait states inserted, wrapping |

## Verification
The hardest situation to reach is a serialised pair whose two operands interact on the same address. Examples are a write by operand 0 followed by a read by operand 1 in one bank, and two banks that share a home bus. Only some configurations expose these cases. The bench therefore sweeps all sixteen region maps with one fixed pseudo-random stream. In that stream operand 1 often reuses operand 0's address. A configuration-independent reference memory predicts every result and every wait, and the read checksum of each map is compared with the all-dual baseline.

// File: rtl/dpe_pkg.sv
package dpe_pkg;
  localparam int NUM_BUS = 2;

  typedef struct packed {
    logic src0;   // bus carrying operand 0 read
    logic src1;   // bus carrying operand 1 read
    logic hold0;  // operand 0 result captured during a wait
    logic fwd1;   // operand 1 takes operand 0 write data
    logic we0;
    logic we1;
  } rsp_meta_t;
endpackage

// File: rtl/dpe_route.sv
module dpe_route #(
  parameter int ADDR_W   = 6,
  parameter int REG_BITS = 2
) (
  input  logic [(1<<REG_BITS)-1:0] cfg_single,
  input  logic [ADDR_W-1:0]        addr0,
  input  logic [ADDR_W-1:0]        addr1,
  input  logic                     second,
  output logic [1:0]               bus_en,
  output logic [1:0]               bus_sel,
  output logic                     op0_bus,
  output logic                     op1_bus,
  output logic                     collide
);
  logic [REG_BITS-1:0] r0, r1;
  logic s0, s1, h0, h1;

  assign r0 = addr0[ADDR_W-1 -: REG_BITS];
  assign r1 = addr1[ADDR_W-1 -: REG_BITS];
  assign s0 = cfg_single[r0];
  assign s1 = cfg_single[r1];
  assign h0 = r0[0];
  assign h1 = r1[0];

  always_comb begin
    collide = s0 && s1 && (h0 == h1);
    if (s0) begin
      op0_bus = h0;
      op1_bus = s1 ? h1 : ~h0;
    end else if (s1) begin
      op1_bus = h1;
      op0_bus = ~h1;
    end else begin
      op0_bus = 1'b0;
      op1_bus = 1'b1;
    end
    bus_en  = '0;
    bus_sel = '0;
    if (collide) begin
      bus_en[h0]  = 1'b1;
      bus_sel[h0] = second;
    end else begin
      bus_en           = 2'b11;
      bus_sel[op1_bus] = 1'b1;
    end
  end
endmodule

// File: rtl/dpe_region.sv
module dpe_region #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 8,
  parameter int HOME   = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   single,
  input  logic [1:0]             en,
  input  logic [1:0]             we,
  input  logic [1:0][IDX_W-1:0]  addr,
  input  logic [1:0][DATA_W-1:0] wdata,
  output logic [1:0][DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (en[p] && !we[p]) rdata[p] <= mem[addr[p]];
    end
    for (int p = 0; p < 2; p++) begin
      if (en[p] && we[p]) mem[addr[p]] <= wdata[p];
    end
  end

  // A single-port bank is only ever reached through its home bus.
  p_single_one_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
    single |-> !en[1-HOME]);
endmodule

// File: rtl/dpe_arbiter.sv
module dpe_arbiter #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int REG_BITS = 2,
  parameter int CNT_W    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [(1<<REG_BITS)-1:0] cfg_single,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [ADDR_W-1:0]        addr0,
  input  logic                     we0,
  input  logic [DATA_W-1:0]        wdata0,
  input  logic [ADDR_W-1:0]        addr1,
  input  logic                     we1,
  input  logic [DATA_W-1:0]        wdata1,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rdata0,
  output logic [DATA_W-1:0]        rdata1,
  output logic [CNT_W-1:0]         stall_count
);
  import dpe_pkg::*;
  localparam int NREG  = 1 << REG_BITS;
  localparam int IDX_W = ADDR_W - REG_BITS;

  logic second, collide, op0_bus, op1_bus, accept;
  logic [1:0] bus_en, bus_sel;
  logic [NUM_BUS-1:0][ADDR_W-1:0] bus_addr;
  logic [NUM_BUS-1:0]             bus_we;
  logic [NUM_BUS-1:0][DATA_W-1:0] bus_wd;
  logic [NUM_BUS-1:0][DATA_W-1:0] bus_rd;
  logic [REG_BITS-1:0]            bus_reg_q [NUM_BUS];
  logic [1:0][DATA_W-1:0]         rg_rd [NREG];
  rsp_meta_t                      meta_q;
  logic [DATA_W-1:0]              hold_q, fwd_q;

  dpe_route #(.ADDR_W(ADDR_W), .REG_BITS(REG_BITS)) i_route (
    .cfg_single(cfg_single), .addr0(addr0), .addr1(addr1), .second(second),
    .bus_en(bus_en), .bus_sel(bus_sel), .op0_bus(op0_bus), .op1_bus(op1_bus),
    .collide(collide));

  assign in_ready = !collide || second;
  assign accept   = in_valid && in_ready;

  always_comb begin
    for (int b = 0; b < NUM_BUS; b++) begin
      bus_addr[b] = bus_sel[b] ? addr1  : addr0;
      bus_we[b]   = bus_sel[b] ? we1    : we0;
      bus_wd[b]   = bus_sel[b] ? wdata1 : wdata0;
      bus_rd[b]   = rg_rd[bus_reg_q[b]][b];
    end
  end

  for (genvar k = 0; k < NREG; k++) begin : g_region
    logic [1:0]             en_k;
    logic [1:0][IDX_W-1:0]  idx_k;
    always_comb begin
      for (int b = 0; b < NUM_BUS; b++) begin
        en_k[b]  = in_valid && bus_en[b] &&
                   (bus_addr[b][ADDR_W-1 -: REG_BITS] == REG_BITS'(k));
        idx_k[b] = bus_addr[b][IDX_W-1:0];
      end
    end
    dpe_region #(.IDX_W(IDX_W), .DATA_W(DATA_W), .HOME(k % 2)) i_region (
      .clk(clk), .rst_n(rst_n), .single(cfg_single[k]), .en(en_k),
      .we(bus_we), .addr(idx_k), .wdata(bus_wd), .rdata(rg_rd[k]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      second      <= 1'b0;
      rsp_valid   <= 1'b0;
      stall_count <= '0;
      meta_q      <= '0;
      hold_q      <= '0;
      fwd_q       <= '0;
      for (int b = 0; b < NUM_BUS; b++) bus_reg_q[b] <= '0;
    end else begin
      second    <= in_valid && collide && !second;
      rsp_valid <= accept;
      if (in_valid && !in_ready) stall_count <= stall_count + 1'b1;
      for (int b = 0; b < NUM_BUS; b++) begin
        if (in_valid && bus_en[b]) bus_reg_q[b] <= bus_addr[b][ADDR_W-1 -: REG_BITS];
      end
      if (accept) begin
        meta_q.src0  <= op0_bus;
        meta_q.src1  <= op1_bus;
        meta_q.hold0 <= collide;
        meta_q.fwd1  <= !collide && we0 && !we1 && (addr0 == addr1);
        meta_q.we0   <= we0;
        meta_q.we1   <= we1;
        fwd_q        <= wdata0;
        if (collide) hold_q <= bus_rd[op0_bus];
      end
    end
  end

  assign rdata0 = meta_q.we0  ? '0 :
                  meta_q.hold0 ? hold_q : bus_rd[meta_q.src0];
  assign rdata1 = meta_q.we1  ? '0 :
                  meta_q.fwd1 ? fwd_q  : bus_rd[meta_q.src1];

  logic sp0_chk, sp1_chk;
  assign sp0_chk = cfg_single[addr0[ADDR_W-1 -: REG_BITS]];
  assign sp1_chk = cfg_single[addr1[ADDR_W-1 -: REG_BITS]];

  p_wait_single_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (!in_valid || in_ready));
  p_rsp_follows_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> rsp_valid);
  p_no_rsp_in_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> !rsp_valid);
  p_stall_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (stall_count == $past(stall_count) + 1'b1));
  p_steer_no_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(sp0_chk && sp1_chk)) |-> in_ready);
endmodule

// File: tb/test_dpe_arbiter.sv
module test_dpe_arbiter;
  localparam int AW = 6, DW = 8, RB = 2, CW = 16;
  localparam int NR = 1 << RB;
  localparam int DEPTH = 1 << AW;
  localparam int NPAIRS = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NR-1:0] cfg_single = '0;
  logic in_valid = 1'b0, in_ready;
  logic [AW-1:0] addr0 = '0, addr1 = '0;
  logic we0 = 1'b0, we1 = 1'b0;
  logic [DW-1:0] wdata0 = '0, wdata1 = '0;
  logic rsp_valid;
  logic [DW-1:0] rdata0, rdata1;
  logic [CW-1:0] stall_count;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [DW-1:0] ref_mem [DEPTH];
  int exp_stalls;
  int csum, base_csum;

  always #10 clk = ~clk;

  dpe_arbiter #(.ADDR_W(AW), .DATA_W(DW), .REG_BITS(RB), .CNT_W(CW)) i_dpe_arbiter (
    .clk(clk), .rst_n(rst_n), .cfg_single(cfg_single), .in_valid(in_valid),
    .in_ready(in_ready), .addr0(addr0), .we0(we0), .wdata0(wdata0),
    .addr1(addr1), .we1(we1), .wdata1(wdata1), .rsp_valid(rsp_valid),
    .rdata0(rdata0), .rdata1(rdata1), .stall_count(stall_count));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d cfg=%b", req, act, exp, cfg_single);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Issue one pair and check waits (R2, R4, R5), response timing (R3, R10)
  // and data (R6, R9) against the sequential reference.
  task automatic issue(input logic [AW-1:0] a0, input logic w0, input logic [DW-1:0] d0,
                       input logic [AW-1:0] a1, input logic w1, input logic [DW-1:0] d1);
    int waits, exp_wait;
    logic [DW-1:0] e0, e1;
    logic s0, s1;
    s0 = cfg_single[a0[AW-1 -: RB]];
    s1 = cfg_single[a1[AW-1 -: RB]];
    exp_wait = (s0 && s1 && (a0[AW-RB] == a1[AW-RB])) ? 1 : 0;
    e0 = w0 ? '0 : ref_mem[a0];
    if (w0) ref_mem[a0] = d0;
    e1 = w1 ? '0 : ref_mem[a1];
    if (w1) ref_mem[a1] = d1;
    @(negedge clk);
    addr0 = a0; we0 = w0; wdata0 = d0;
    addr1 = a1; we1 = w1; wdata1 = d1;
    in_valid = 1'b1;
    #1;
    waits = 0;
    while (!in_ready && waits < 4) begin
      waits++;
      @(negedge clk);
      check("R10 no response in wait", int'(rsp_valid), 0);
      #1;
    end
    if (exp_wait != 0) check("R4 R2 wait cycles on shared home bus", waits, 1);
    else if (s0 || s1) check("R5 steered pair no wait", waits, 0);
    else check("R3 dual pair no wait", waits, 0);
    exp_stalls += waits;
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 response valid after accept", int'(rsp_valid), 1);
    check(w0 ? "R9 operand0 write result" : "R6 operand0 read", int'(rdata0), int'(e0));
    check(w1 ? "R9 operand1 write result" : "R6 operand1 read", int'(rdata1), int'(e1));
    csum += int'(rdata0) * 3 + int'(rdata1);
    @(negedge clk);
    check("R10 single response per pair", int'(rsp_valid), 0);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    logic [AW-1:0] a0, a1;
    for (int c = 0; c < (1 << NR); c++) begin
      cfg_single = NR'(c);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 rsp_valid in reset", int'(rsp_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 stall_count after reset", int'(stall_count), 0);
      check("R1 rsp_valid after reset", int'(rsp_valid), 0);
      exp_stalls = 0;
      csum = 0;
      for (int i = 0; i < DEPTH / 2; i++) begin
        issue(AW'(i), 1'b1, DW'(i * 7 + 3), AW'(i + DEPTH / 2), 1'b1, DW'(i * 5 + 11));
      end
      // Same-address pairs: forwarding and write ordering (R6).
      issue(6'd5, 1'b1, 8'hA5, 6'd5, 1'b0, 8'h00);
      issue(6'd5, 1'b1, 8'h11, 6'd5, 1'b1, 8'h22);
      issue(6'd5, 1'b0, 8'h00, 6'd5, 1'b0, 8'h00);
      lfsr = 32'h1ACE_B00C;
      for (int n = 0; n < NPAIRS; n++) begin
        lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
        a0 = lfsr[AW-1:0];
        a1 = lfsr[27] ? a0 : lfsr[AW+7:8];
        issue(a0, lfsr[24], lfsr[23:16], a1, lfsr[25], lfsr[31:24] ^ 8'h5C);
      end
      check("R8 stall counter total", int'(stall_count), exp_stalls);
      if (c == 0) begin
        base_csum = csum;
        check("R5 all-dual map never waits", exp_stalls, 0);
      end else begin
        check("R7 read checksum equals all-dual map", csum, base_csum);
      end
    end
    finish_run();
  end
endmodule